// File: doc/BRIEF.md
# Write-Only Serial Clock-Enable Controller

This block sits beside a bank of five clock outputs that all come from one source clock. A two-wire serial host writes a short burst to the block, and the burst sets which outputs run and which are held low. The block only receives. It never returns data, and it cannot be addressed at a sub-register. The host sends a start. It then sends the address byte 0xD2, two filler bytes that the block acknowledges but does not use, and up to two control bytes. Any further bytes are acknowledged and dropped, and the host ends with a stop. To change the second control byte, the host must send the first control byte in the same burst.

A faster system clock samples both bus lines through synchronizers, and a small edge detector reports start, stop, SCL rising and SCL falling. A receive state machine decodes these events. Its states are S_IDLE, S_SHIFT, S_BYTE_DONE, S_ACK_LOW, S_ACK_HIGH and S_IGNORE. A start moves any state to S_SHIFT with the byte index cleared. A stop moves any other state to S_IDLE. S_SHIFT takes eight bits on SCL rises and then goes to S_BYTE_DONE. On the next SCL fall, S_BYTE_DONE goes to S_IGNORE if the address byte is wrong, and to S_ACK_LOW otherwise. S_ACK_LOW goes to S_ACK_HIGH on the ninth SCL rise. S_ACK_HIGH returns to S_SHIFT on the SCL fall that follows. The acknowledge is an open-drain pull-down, driven while the state is S_ACK_LOW or S_ACK_HIGH.

Each enable bit is re-timed on the falling edge of the source clock and then ANDed with that clock. An output therefore either passes whole high phases or stays low.

Top module: `i2c_clkgate_ctrl`

## Requirements
- R1: After reset, all five outputs are enabled and follow clk_src, and sda_oe is low.
- R2: A start begins a new transfer at the address byte from any state, including in the middle of a transfer. A start is SDA falling while SCL is high. A stop ends the transfer. A stop is SDA rising while SCL is high.
- R3: Bits are taken MSB first on SCL rising edges. For an acknowledge, sda_oe goes high after the SCL fall that ends the 8th bit and stays high through the 9th SCL pulse, so SDA reads low while SCL is high in that pulse.
- R4: Only the byte 0xD2 is acknowledged as the first byte (address 1101001 followed by the write bit 0). Any other first byte is not acknowledged, including 0xD3 (read). The block then ignores the bus until the next start or stop, and the outputs do not change.
- R5: The 2nd and 3rd bytes are always acknowledged, and their contents have no effect.
- R6: The 4th byte is control byte 0, where 1 means enabled. Bit 0 drives output 0, bit 1 drives output 1, bit 6 drives output 2 and bit 7 drives output 3. Bits 5 to 2 have no effect.
- R7: The 5th byte is control byte 1. Its bit 0 drives output 4, and bits 7 to 1 have no effect. A transfer that stops after the 4th byte leaves output 4 unchanged.
- R8: Bytes after the 5th are acknowledged and change nothing.
- R9: A control byte takes effect at its own acknowledge, before the transfer ends.
- R10: A disabled output stays low. An enable change takes effect at a falling edge of clk_src, so no output high pulse is shorter than the high phase of clk_src.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line, as seen on the wired bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain acknowledge) |
| clk_src | input | 1 | Source clock to be distributed |
| clk_out | output | 5 | Gated copies of clk_src, one per output |

## Verification
An SCL edge reaches the state machine three system cycles after it occurs on the pin: two synchronizer flops and one state register. So sda_oe rises about three cycles into the low phase that follows the 8th bit. The bench drives each bus change five cycles into a low phase and samples the acknowledge in the middle of the ninth high phase, which clears that latency with margin. A new enable reaches its output after two falling edges of clk_src. The output checks therefore wait forty system cycles and then watch eight full periods of clk_src. Throughout the run, every output high pulse is timed against the high phase of clk_src.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;
    localparam int NUM_OUT = 5;
    localparam int BYTE_W  = 8;
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int IDX_W   = 3;

    localparam logic [IDX_W-1:0] IDX_ADDR  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CMD   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CNT   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CTL0  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_CTL1  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_EXTRA = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_BYTE_DONE,
        S_ACK_LOW,
        S_ACK_HIGH,
        S_IGNORE
    } rx_state_t;
endpackage

// File: rtl/bus_sync.sv
`timescale 1ns/1ps
module bus_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '1;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/bus_cond.sv
`timescale 1ns/1ps
module bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/rx_fsm.sv
`timescale 1ns/1ps
module rx_fsm
    import clkctl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    output logic               sda_oe,
    output logic [NUM_OUT-1:0] enables
);
    localparam logic [BYTE_W-1:0] ADDR_WR = {SLAVE_ADDR, 1'b0};

    rx_state_t         state;
    rx_state_t         state_n;
    logic [BYTE_W-1:0] shreg;
    logic [BIT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  byte_idx;
    logic [3:0]        ctl0_q;   // {b7, b6, b1, b0}
    logic              ctl1_q;
    logic              addr_bad;

    assign addr_bad = (byte_idx == IDX_ADDR) && (shreg != ADDR_WR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = S_SHIFT;
        end else if (stop_det) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      state_n = S_IDLE;
                S_SHIFT:     if (scl_rise && bit_cnt == BIT_W'(BYTE_W-1)) state_n = S_BYTE_DONE;
                S_BYTE_DONE: if (scl_fall) state_n = addr_bad ? S_IGNORE : S_ACK_LOW;
                S_ACK_LOW:   if (scl_rise) state_n = S_ACK_HIGH;
                S_ACK_HIGH:  if (scl_fall) state_n = S_SHIFT;
                S_IGNORE:    state_n = S_IGNORE;
                default:     state_n = S_IDLE;
            endcase
        end
    end

    // datapath: shift register, counters, control bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_idx <= IDX_ADDR;
            ctl0_q   <= '1;
            ctl1_q   <= 1'b1;
        end else if (start_det) begin
            bit_cnt  <= '0;
            byte_idx <= IDX_ADDR;
        end else if (!stop_det) begin
            unique case (state)
                S_SHIFT: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                S_BYTE_DONE: begin
                    if (scl_fall && !addr_bad) begin
                        if (byte_idx == IDX_CTL0)
                            ctl0_q <= {shreg[7], shreg[6], shreg[1], shreg[0]};
                        else if (byte_idx == IDX_CTL1)
                            ctl1_q <= shreg[0];
                    end
                end
                S_ACK_HIGH: begin
                    if (scl_fall) begin
                        bit_cnt  <= '0;
                        byte_idx <= (byte_idx == IDX_EXTRA) ? IDX_EXTRA : byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe  = (state == S_ACK_LOW) || (state == S_ACK_HIGH);
        enables = {ctl1_q, ctl0_q[3], ctl0_q[2], ctl0_q[1], ctl0_q[0]};
    end

    // R2
    start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_SHIFT && bit_cnt == '0 && byte_idx == IDX_ADDR));

    // R2
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == S_IDLE && !sda_oe));

    // R3
    ack_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R4
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> !sda_oe);

    // R9
    commit_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enables != $past(enables)) |-> sda_oe);
endmodule

// File: rtl/clk_gate_bank.sv
`timescale 1ns/1ps
module clk_gate_bank #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk_src,
    input  logic         rst_n,
    input  logic [N-1:0] en,
    output logic [N-1:0] clk_out
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        logic [STAGES-1:0] rt;
        always_ff @(negedge clk_src or negedge rst_n) begin
            if (!rst_n) rt <= '1;
            else        rt <= {rt[STAGES-2:0], en[i]};
        end
        assign clk_out[i] = clk_src & rt[STAGES-1];
    end
endmodule

// File: rtl/i2c_clkgate_ctrl.sv
`timescale 1ns/1ps
module i2c_clkgate_ctrl
    import clkctl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter int         GATE_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic               clk_src,
    output logic [NUM_OUT-1:0] clk_out
);
    logic [1:0]         bus_s;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    logic [NUM_OUT-1:0] enables;

    bus_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (bus_s)
    );

    bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rx_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .enables   (enables)
    );

    clk_gate_bank #(.N(NUM_OUT), .STAGES(GATE_STAGES)) u_gate (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .en      (enables),
        .clk_out (clk_out)
    );
endmodule

// File: tb/test_i2c_clkgate_ctrl.sv
`timescale 1ns/1ps
module test_i2c_clkgate_ctrl;
    localparam int  CLK_P    = 10;
    localparam real SRC_HALF = 7.0;
    localparam int  HB       = 10;
    localparam int  SETUP    = 5;

    logic       clk = 1'b0;
    logic       clk_src = 1'b0;
    logic       rst_n;
    logic       scl_m;
    logic       sda_m;
    logic       sda_oe;
    logic       sda_bus;
    logic [4:0] clk_out;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;
    always #(SRC_HALF) clk_src = ~clk_src;

    i2c_clkgate_ctrl i_i2c_clkgate_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_m),
        .sda_in  (sda_bus),
        .sda_oe  (sda_oe),
        .clk_src (clk_src),
        .clk_out (clk_out)
    );

    typedef struct {
        string      tag;
        logic [7:0] v;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] act_q[$];
    int         n_tests = 0;
    int         n_fail  = 0;
    int         n_act   = 0;
    int         n_done  = 0;
    int         runt_cnt = 0;
    bit         width_on = 0;
    bit         finished = 0;

    task automatic expect_item(input string tag, input logic [7:0] v);
        exp_t e;
        e.tag = tag;
        e.v   = v;
        exp_q.push_back(e);
    endtask

    task automatic result_item(input logic [7:0] a);
        act_q.push_back(a);
        n_act++;
    endtask

    // monitor: pops and compares as results appear
    initial begin
        forever begin
            exp_t       e;
            logic [7:0] a;
            wait (n_act > n_done);
            a = act_q.pop_front();
            if (exp_q.size() == 0) begin
                e.tag = "scoreboard underflow";
                e.v   = 8'hxx;
            end else begin
                e = exp_q.pop_front();
            end
            n_tests++;
            if (a !== e.v) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", e.tag, a, e.v);
            end
            n_done++;
        end
    end

    // R10: time every output high pulse
    for (genvar g = 0; g < 5; g++) begin : g_width
        realtime t_r = 0.0;
        always @(posedge clk_out[g]) t_r = $realtime;
        always @(negedge clk_out[g])
            if (width_on && ($realtime - t_r) < SRC_HALF - 0.5) runt_cnt++;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        wait_clk(SETUP);
        sda_m = 1'b1;
        wait_clk(HB - SETUP);
        scl_m = 1'b1;
        wait_clk(HB);
        sda_m = 1'b0;
        wait_clk(HB);
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wait_clk(SETUP);
        sda_m = 1'b0;
        wait_clk(HB - SETUP);
        scl_m = 1'b1;
        wait_clk(HB);
        sda_m = 1'b1;
        wait_clk(HB);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit acked, input string tag);
        expect_item(tag, {7'd0, acked});
        for (int k = 7; k >= 0; k--) begin
            wait_clk(SETUP);
            sda_m = b[k];
            wait_clk(HB - SETUP);
            scl_m = 1'b1;
            wait_clk(HB);
            scl_m = 1'b0;
        end
        wait_clk(SETUP);
        sda_m = 1'b1;
        wait_clk(HB - SETUP);
        scl_m = 1'b1;
        wait_clk(HB / 2);
        result_item({7'd0, (sda_bus == 1'b0)});
        wait_clk(HB - HB / 2);
        scl_m = 1'b0;
    endtask

    task automatic check_outs(input logic [4:0] exp, input string tag);
        logic [4:0] seen;
        expect_item(tag, {3'd0, exp});
        wait_clk(40);
        seen = '0;
        repeat (8) begin
            @(posedge clk_src);
            #1;
            seen = seen | clk_out;
        end
        result_item({3'd0, seen});
    endtask

    task automatic write_pre();
        send_byte(8'hD2, 1'b1, "R3 R4 address acked");
        send_byte(8'hA5, 1'b1, "R5 command acked");
        send_byte(8'h5A, 1'b1, "R5 count acked");
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        scl_m = 1'b1;
        sda_m = 1'b1;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        expect_item("R1 sda_oe released", 8'h00);
        result_item({7'd0, sda_oe});
        check_outs(5'h1F, "R1 all outputs run");
        width_on = 1;

        // all off
        i2c_start();
        write_pre();
        send_byte(8'h00, 1'b1, "R6 ctl0 acked");
        send_byte(8'h00, 1'b1, "R7 ctl1 acked");
        i2c_stop();
        check_outs(5'h00, "R6 R7 all disabled held low");

        // only ctl0: output 4 keeps its value
        i2c_start();
        send_byte(8'hD2, 1'b1, "R4 address acked");
        send_byte(8'hFF, 1'b1, "R5 command ignored");
        send_byte(8'h00, 1'b1, "R5 count ignored");
        send_byte(8'hC3, 1'b1, "R6 ctl0 acked");
        i2c_stop();
        check_outs(5'h0F, "R6 R7 map bits 7,6,1,0; out4 kept");

        // unused ctl0 bits
        i2c_start();
        write_pre();
        send_byte(8'h3C, 1'b1, "R6 ctl0 acked");
        i2c_stop();
        check_outs(5'h00, "R6 bits 5..2 no effect");

        // single bits of each byte
        i2c_start();
        write_pre();
        send_byte(8'h41, 1'b1, "R6 ctl0 acked");
        send_byte(8'hFE, 1'b1, "R7 ctl1 acked");
        i2c_stop();
        check_outs(5'h05, "R6 R7 bit6->out2, bit0->out0, ctl1 bits 7..1 no effect");

        i2c_start();
        write_pre();
        send_byte(8'h41, 1'b1, "R6 ctl0 acked");
        send_byte(8'h01, 1'b1, "R7 ctl1 acked");
        i2c_stop();
        check_outs(5'h15, "R7 bit0->out4");

        // wrong address
        i2c_start();
        send_byte(8'hD0, 1'b0, "R4 wrong address not acked");
        send_byte(8'h00, 1'b0, "R4 ignored byte");
        send_byte(8'h00, 1'b0, "R4 ignored byte");
        send_byte(8'hFF, 1'b0, "R4 ignored byte");
        send_byte(8'h01, 1'b0, "R4 ignored byte");
        i2c_stop();
        check_outs(5'h15, "R4 outputs unchanged after wrong address");

        // read bit set
        i2c_start();
        send_byte(8'hD3, 1'b0, "R4 read address not acked");
        send_byte(8'h00, 1'b0, "R4 ignored byte");
        send_byte(8'h00, 1'b0, "R4 ignored byte");
        send_byte(8'hFF, 1'b0, "R4 ignored byte");
        i2c_stop();
        check_outs(5'h15, "R4 outputs unchanged after read");

        // extra bytes
        i2c_start();
        write_pre();
        send_byte(8'hFF, 1'b1, "R6 ctl0 acked");
        send_byte(8'h01, 1'b1, "R7 ctl1 acked");
        send_byte(8'h00, 1'b1, "R8 extra acked");
        send_byte(8'h00, 1'b1, "R8 extra acked");
        i2c_stop();
        check_outs(5'h1F, "R8 extra bytes discarded");

        // repeated start mid-transfer
        i2c_start();
        send_byte(8'hD2, 1'b1, "R2 address acked");
        send_byte(8'h00, 1'b1, "R2 command acked");
        i2c_start();
        write_pre();
        send_byte(8'h00, 1'b1, "R2 ctl0 after restart acked");
        i2c_stop();
        check_outs(5'h10, "R2 restart returns to address byte");

        // commit before stop
        i2c_start();
        write_pre();
        send_byte(8'h03, 1'b1, "R9 ctl0 acked");
        check_outs(5'h13, "R9 applied before stop");
        i2c_stop();

        // reset again, applied while clk_src is low
        width_on = 0;
        @(negedge clk_src);
        #1;
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(5);
        check_outs(5'h1F, "R1 reset restores all enabled");

        expect_item("R10 no short output pulses", 8'h00);
        result_item(8'(runt_cnt));

        wait (n_done == n_act);
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end
endmodule